// File: doc/BRIEF.md
# Serial Tuning-Word Loader

This block receives 16-bit words from a three-wire serial master (serial clock, serial data, active-low frame select) and routes each one into a bank of tuning registers for a direct-synthesis core: a 16-bit control register, two 28-bit frequency registers and two 12-bit phase registers. The serial pins are sampled through synchronizers in the system clock domain. Every complete word raises a one-cycle write strobe, and the bank is updated on the following clock edge.

The two most significant bits of each word address its destination. Frequency registers are wider than a word, so each frequency write carries 14 payload bits. A control bit selects how those bits are applied. In full-word mode two consecutive writes to the same frequency register form one 28-bit value, and that value reaches the output in a single step. With the bit cleared, each write replaces either the upper or the lower 14 bits, as a second control bit selects.

The register contents drive the synthesis core directly through the output ports.

Top module: `dds_reg_loader`

## Requirements
- R1: While reset is asserted and right after it, every register output is zero and the write strobe is low.
- R2: With the frame select low, one data bit is taken on each falling edge of the serial clock, most significant bit first. The 16th bit completes a word, and `wr_stb_o` then pulses high for exactly one system clock.
- R3: If the frame select rises before 16 bits have arrived, the partial word is discarded. No strobe is produced and no register changes.
- R4: A word with bits 15:14 = 00 loads the whole word into the control register, so `ctrl_o[15:14]` always reads 00. Control bit 13 is the full-word mode bit and control bit 12 is the half-select bit.
- R5: A word with bits 15:14 = 11 loads bits 11:0 into phase register 1 when bit 13 is 1, and into phase register 0 when bit 13 is 0. Bit 12 has no effect.
- R6: Bits 15:14 = 01 address frequency register 0 and 10 address frequency register 1, with the payload in bits 13:0. In full-word mode the first write supplies the lower 14 bits and the second supplies the upper 14 bits. The register changes only after the second write, in one step, and no half-updated value ever appears at the output.
- R7: In full-word mode, if a frequency word arrives while a lower half is held for the other frequency register, that word is taken as a new first half. The held half is dropped and neither register changes.
- R8: A control write drops any held lower half. Phase writes between the two halves of a pair leave the held half in place.
- R9: With full-word mode off, a frequency write replaces only bits 27:14 when control bit 12 is 1, and only bits 13:0 when it is 0. The other half keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; idles high, data taken on falling edges |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| frame_n_i | input | 1 | Active-low frame select |
| ctrl_o | output | 16 | Control register contents |
| freq0_o | output | 28 | Frequency register 0 |
| freq1_o | output | 28 | Frequency register 1 |
| phase0_o | output | 12 | Phase register 0 |
| phase1_o | output | 12 | Phase register 1 |
| wr_stb_o | output | 1 | One-cycle pulse per completed word |

## Verification
A wrong bit count or a wrong shift direction in the receiver shows up within the same frame, as a missing strobe or as the wrong register or value being written. A stuck or misrouted held half is invisible at the ports until the next frequency write completes. The bench therefore issues pairs that are broken by control writes, by phase writes and by writes to the other register, and it checks the outputs after every frame. A monitor compares both frequency outputs every clock against the old and new expected values, so a half-updated value seen for even a single cycle is reported.

// File: rtl/dds_ldr_pkg.sv
package dds_ldr_pkg;
    localparam int WORD_W       = 16;
    localparam int FREQ_W       = 28;
    localparam int PHASE_W      = 12;
    localparam int HALF_W       = FREQ_W / 2;
    localparam int CNT_W        = $clog2(WORD_W);
    localparam int FULL_BIT     = 13;
    localparam int HALF_SEL_BIT = 12;
    localparam int PH_SEL_BIT   = 13;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [FREQ_W-1:0]  freq_t;
    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [HALF_W-1:0]  half_t;

    typedef enum logic [1:0] {
        DST_CTRL = 2'b00,
        DST_F0   = 2'b01,
        DST_F1   = 2'b10,
        DST_PH   = 2'b11
    } dst_e;

    typedef struct packed {
        word_t  ctrl;
        freq_t  f0;
        freq_t  f1;
        phase_t p0;
        phase_t p1;
    } regset_t;

    function automatic dst_e word_dst(word_t w);
        return dst_e'(w[WORD_W-1 -: 2]);
    endfunction

    function automatic half_t word_half(word_t w);
        return w[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/dds_ldr_sync.sv
module dds_ldr_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= {STAGES{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dds_ldr_shift.sv
module dds_ldr_shift
    import dds_ldr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk_s,
    input  logic  sdat_s,
    input  logic  frame_n_s,
    output word_t word_o,
    output logic  stb_o
);
    logic             sclk_d;
    logic [CNT_W-1:0] cnt_q;
    word_t            shreg_q;
    logic             fall;

    assign fall = sclk_d & ~sclk_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d  <= 1'b1;
            cnt_q   <= '0;
            shreg_q <= '0;
            word_o  <= '0;
            stb_o   <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            stb_o  <= 1'b0;
            if (frame_n_s) begin
                cnt_q <= '0;
            end else if (fall) begin
                shreg_q <= {shreg_q[WORD_W-2:0], sdat_s};
                if (cnt_q == CNT_W'(WORD_W - 1)) begin
                    word_o <= {shreg_q[WORD_W-2:0], sdat_s};
                    stb_o  <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dds_ldr_regs.sv
module dds_ldr_regs
    import dds_ldr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  word_t   word_i,
    input  logic    stb_i,
    output regset_t regs_o,
    output logic    pend_o
);
    regset_t regs_q, regs_n;
    logic    pend_q, pend_n;
    logic    pidx_q, pidx_n;
    half_t   hold_q, hold_n;
    logic    tgt;
    logic    wr;
    freq_t   upd;

    always_comb begin
        regs_n = regs_q;
        pend_n = pend_q;
        pidx_n = pidx_q;
        hold_n = hold_q;
        tgt    = 1'b0;
        wr     = 1'b0;
        upd    = '0;
        if (stb_i) begin
            unique case (word_dst(word_i))
                DST_CTRL: begin
                    regs_n.ctrl = word_i;
                    pend_n      = 1'b0;
                end
                DST_F0, DST_F1: begin
                    tgt = (word_dst(word_i) == DST_F1);
                    upd = tgt ? regs_q.f1 : regs_q.f0;
                    if (regs_q.ctrl[FULL_BIT]) begin
                        if (pend_q && (pidx_q == tgt)) begin
                            upd    = {word_half(word_i), hold_q};
                            wr     = 1'b1;
                            pend_n = 1'b0;
                        end else begin
                            hold_n = word_half(word_i);
                            pidx_n = tgt;
                            pend_n = 1'b1;
                        end
                    end else begin
                        wr = 1'b1;
                        if (regs_q.ctrl[HALF_SEL_BIT]) begin
                            upd[FREQ_W-1:HALF_W] = word_half(word_i);
                        end else begin
                            upd[HALF_W-1:0] = word_half(word_i);
                        end
                    end
                    if (wr) begin
                        if (tgt) begin
                            regs_n.f1 = upd;
                        end else begin
                            regs_n.f0 = upd;
                        end
                    end
                end
                DST_PH: begin
                    if (word_i[PH_SEL_BIT]) begin
                        regs_n.p1 = word_i[PHASE_W-1:0];
                    end else begin
                        regs_n.p0 = word_i[PHASE_W-1:0];
                    end
                end
                default: begin
                    regs_n = regs_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
            pend_q <= 1'b0;
            pidx_q <= 1'b0;
            hold_q <= '0;
        end else begin
            regs_q <= regs_n;
            pend_q <= pend_n;
            pidx_q <= pidx_n;
            hold_q <= hold_n;
        end
    end

    assign regs_o = regs_q;
    assign pend_o = pend_q;
endmodule

// File: rtl/dds_reg_loader.sv
module dds_reg_loader
    import dds_ldr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ser_clk_i,
    input  logic               ser_dat_i,
    input  logic               frame_n_i,
    output logic [WORD_W-1:0]  ctrl_o,
    output logic [FREQ_W-1:0]  freq0_o,
    output logic [FREQ_W-1:0]  freq1_o,
    output logic [PHASE_W-1:0] phase0_o,
    output logic [PHASE_W-1:0] phase1_o,
    output logic               wr_stb_o
);
    localparam logic [2:0] PIN_IDLE = 3'b110;

    logic [2:0] pins_s;
    word_t      word_w;
    logic       stb_w;
    regset_t    regs_w;
    logic       pend_w;

    dds_ldr_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d_i({ser_clk_i, frame_n_i, ser_dat_i}),
        .q_o(pins_s)
    );

    dds_ldr_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sclk_s   (pins_s[2]),
        .sdat_s   (pins_s[0]),
        .frame_n_s(pins_s[1]),
        .word_o   (word_w),
        .stb_o    (stb_w)
    );

    dds_ldr_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .word_i(word_w),
        .stb_i (stb_w),
        .regs_o(regs_w),
        .pend_o(pend_w)
    );

    assign ctrl_o   = regs_w.ctrl;
    assign freq0_o  = regs_w.f0;
    assign freq1_o  = regs_w.f1;
    assign phase0_o = regs_w.p0;
    assign phase1_o = regs_w.p1;
    assign wr_stb_o = stb_w;
endmodule

// File: rtl/dds_reg_loader_chk.sv
module dds_reg_loader_chk
    import dds_ldr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_stb,
    input logic [WORD_W-1:0]  ctrl,
    input logic [FREQ_W-1:0]  freq0,
    input logic [FREQ_W-1:0]  freq1,
    input logic [PHASE_W-1:0] phase0,
    input logic [PHASE_W-1:0] phase1,
    input logic               pend
);
    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    p_ctrl_addr_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ctrl[WORD_W-1 -: 2] == 2'b00);

    p_phase0_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(phase0));

    p_phase1_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(phase1));

    p_freq0_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(freq0));

    p_freq1_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(freq1));

    p_first_half_f0_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl[FULL_BIT] && !pend) |=> $stable(freq0));

    p_first_half_f1_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl[FULL_BIT] && !pend) |=> $stable(freq1));
endmodule

bind dds_reg_loader dds_reg_loader_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_stb(wr_stb_o),
    .ctrl  (ctrl_o),
    .freq0 (freq0_o),
    .freq1 (freq1_o),
    .phase0(phase0_o),
    .phase1(phase1_o),
    .pend  (pend_w)
);

// File: tb/dds_reg_loader_tb_top.sv
module dds_reg_loader_tb_top;
    localparam int HP = 4;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b1;
    logic ser_dat = 1'b0;
    logic frame_n = 1'b1;
    logic [15:0] ctrl_o;
    logic [27:0] freq0_o, freq1_o;
    logic [11:0] phase0_o, phase1_o;
    logic wr_stb_o;

    always #2 clk = ~clk;

    dds_reg_loader dut_i (
        .clk(clk), .rst(rst),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .frame_n_i(frame_n),
        .ctrl_o(ctrl_o), .freq0_o(freq0_o), .freq1_o(freq1_o),
        .phase0_o(phase0_o), .phase1_o(phase1_o), .wr_stb_o(wr_stb_o)
    );

    int errs = 0;
    int checks = 0;
    bit done = 0;

    logic [15:0] m_ctrl = '0;
    logic [27:0] m_f0 = '0, m_f1 = '0, o_f0 = '0, o_f1 = '0;
    logic [11:0] m_p0 = '0, m_p1 = '0;
    logic        m_pend = 0, m_pidx = 0;
    logic [13:0] m_hold = '0;

    int stb_cnt = 0;
    bit mon_en = 0;
    bit mon_bad = 0;

    always @(negedge clk) begin
        if (wr_stb_o) stb_cnt++;
        if (mon_en && !rst) begin
            if ((freq0_o != m_f0 && freq0_o != o_f0) ||
                (freq1_o != m_f1 && freq1_o != o_f1))
                mon_bad = 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        check(ctrl_o == m_ctrl, req, "ctrl", 32'(ctrl_o), 32'(m_ctrl));
        check(freq0_o == m_f0, req, "freq0", 32'(freq0_o), 32'(m_f0));
        check(freq1_o == m_f1, req, "freq1", 32'(freq1_o), 32'(m_f1));
        check(phase0_o == m_p0, req, "phase0", 32'(phase0_o), 32'(m_p0));
        check(phase1_o == m_p1, req, "phase1", 32'(phase1_o), 32'(m_p1));
    endtask

    task automatic model(input logic [15:0] w);
        logic idx;
        logic [27:0] cur;
        case (w[15:14])
            2'b00: begin m_ctrl = w; m_pend = 0; end
            2'b11: begin
                if (w[13]) m_p1 = w[11:0]; else m_p0 = w[11:0];
            end
            default: begin
                idx = w[15];
                cur = idx ? m_f1 : m_f0;
                if (m_ctrl[13]) begin
                    if (m_pend && m_pidx == idx) begin
                        cur = {w[13:0], m_hold};
                        m_pend = 0;
                    end else begin
                        m_hold = w[13:0];
                        m_pidx = idx;
                        m_pend = 1;
                    end
                end else if (m_ctrl[12]) begin
                    cur[27:14] = w[13:0];
                end else begin
                    cur[13:0] = w[13:0];
                end
                if (idx) m_f1 = cur; else m_f0 = cur;
            end
        endcase
    endtask

    task automatic shift_bits(input logic [15:0] w, input int n);
        frame_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 15; i > 15 - n; i--) begin
            ser_dat = w[i];
            ser_clk = 1'b1;
            repeat (HP) @(negedge clk);
            ser_clk = 1'b0;
            repeat (HP) @(negedge clk);
        end
        ser_clk = 1'b1;
        repeat (HP) @(negedge clk);
        frame_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w, input string req);
        o_f0 = m_f0;
        o_f1 = m_f1;
        model(w);
        stb_cnt = 0;
        mon_bad = 0;
        mon_en = 1;
        shift_bits(w, 16);
        mon_en = 0;
        check(stb_cnt == 1, "R2", "strobe count", 32'(stb_cnt), 32'd1);
        check(!mon_bad, "R6", "half-updated frequency seen", 32'(mon_bad), 32'd0);
        check_regs(req);
        o_f0 = m_f0;
        o_f1 = m_f1;
    endtask

    task automatic partial(input logic [15:0] w, input int n);
        stb_cnt = 0;
        shift_bits(w, n);
        check(stb_cnt == 0, "R3", "strobe on partial word", 32'(stb_cnt), 32'd0);
        check_regs("R3");
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (5) @(negedge clk);
        check(wr_stb_o == 1'b0, "R1", "strobe in reset", 32'(wr_stb_o), 32'd0);
        check_regs("R1");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_regs("R1");

        frame(16'h2000, "R4");
        frame(16'h5ABC, "R6");
        frame(16'h4F0F, "R6");
        frame(16'h4123, "R7");
        frame(16'h8456, "R7");
        frame(16'h8789, "R7");
        frame(16'h4AAA, "R8");
        frame(16'hD123, "R8");
        frame(16'h7FFF, "R8");
        frame(16'h4555, "R8");
        frame(16'h2000, "R8");
        frame(16'h4666, "R8");
        frame(16'h1000, "R9");
        frame(16'hBFFF, "R9");
        frame(16'h0000, "R9");
        frame(16'h8001, "R9");
        frame(16'hD123, "R5");
        frame(16'hEFFF, "R5");
        frame(16'hF000, "R5");
        partial(16'h7FFF, 9);
        partial(16'hC3C3, 15);
        frame(16'h3FFF, "R4");

        for (int k = 0; k < 90; k++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (($urandom % 8) == 0) partial(w, 1 + int'($urandom % 15));
            else frame(w, "R6 R9 random");
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule